// File: doc/BRIEF.md
# Dual-Direction Ripple Magnitude Comparator

This block compares two unsigned operands and reports whether the first is strictly greater than the second. It computes that answer twice, with two ripple chains built in different ways.

The upward chain is a row of identical single-carry cells. It starts at the least significant bit with a carry of 0. Each cell passes the carry on when its two operand bits match. When they differ, it replaces the carry with the bit of A. The downward chain starts at the most significant bit and carries a pair of signals. The first, "decided greater", is set once a higher bit has already shown A ahead. The second, "equal so far", stays set while every bit seen so far matches.

Both answers are outputs, and so is a flag that is 1 when the two answers agree. An equality output comes from the final "equal so far" signal. Every carry between cells, in both chains, is also brought out so that the progress of each chain can be watched from outside. The block is purely combinational and has no clock or reset.

Top module: `ripple_cmp_dual`

## Requirements
- R1: `gt_up` is 1 exactly when `op_a` is greater than `op_b` as unsigned numbers.
- R2: `up_carry[0]` is 0. For each bit i, `up_carry[i+1]` is 1 exactly when `op_a[i:0]` is greater than `op_b[i:0]` as unsigned numbers. In other words, the cell output equals `op_a[i]` when the two bits differ and equals `up_carry[i]` when they match. `gt_up` equals `up_carry[W]`.
- R3: `gt_down` is 1 exactly when `op_a` is greater than `op_b` as unsigned numbers. `gt_down` equals `dn_g[0]`.
- R4: The entry pair is `dn_g[W]`=0 and `dn_e[W]`=1. For i from 0 to W-1:
  - `dn_e[i]` is 1 exactly when `op_a[W-1:i]` equals `op_b[W-1:i]`.
  - `dn_g[i]` is 1 exactly when `op_a[W-1:i]` is greater than `op_b[W-1:i]`.

  So once `dn_g` is set at some position, it stays set at every lower index, and `dn_g[i]` and `dn_e[i]` are never both 1.
- R5: `agree` is 1 exactly when `gt_up` equals `gt_down`. For every operand pair of a correct design, that means `agree` is 1.
- R6: `equal` is 1 exactly when `op_a` equals `op_b`. In that case `gt_up` and `gt_down` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W (8) | First unsigned operand; bit W-1 is the most significant |
| op_b | input | W (8) | Second unsigned operand |
| gt_up | output | 1 | A>B answer of the upward single-carry chain |
| gt_down | output | 1 | A>B answer of the downward two-signal chain |
| agree | output | 1 | 1 when both chain answers are the same |
| equal | output | 1 | 1 when the operands are equal (final equal-so-far signal) |
| up_carry | output | W+1 (9) | Upward carries; index 0 is the entry, index i+1 leaves bit i |
| dn_g | output | W+1 (9) | Downward "decided greater"; index W is the entry, index i leaves bit i |
| dn_e | output | W+1 (9) | Downward "equal so far"; index W is the entry, index i leaves bit i |

## Verification
Because the block has no state, a fault in any cell appears in the same evaluation on the exposed carry vectors, one position above (upward) or below (downward) the faulty cell. It reaches the final answers only when the other operand bits let the wrong carry through. In the upward chain, a bad cell at bit i is visible at `gt_up` only if every bit above i matches. In the downward chain, it is visible only if every bit above it matches, up to the point where a lower bit decides. A full sweep of all operand pairs therefore covers every masking pattern. Comparing the whole carry vectors against prefix comparisons pins a fault to its position even when both final answers happen to be right.

// File: rtl/ripple_cmp_pkg.sv
package ripple_cmp_pkg;

    // Default operand width used by every module of the comparator.
    localparam int unsigned CMP_WIDTH = 8;

    // State passed between downward cells.
    typedef struct packed {
        logic ahead;   // a higher bit has already shown A > B
        logic same;    // every higher bit matched so far
    } dn_link_t;

    // Entry value for the most significant downward cell.
    localparam dn_link_t DN_ENTRY = '{ahead: 1'b0, same: 1'b1};

endpackage

// File: rtl/up_cell.sv
module up_cell (
    input  logic bit_a,
    input  logic bit_b,
    input  logic cin,
    output logic cout
);

    logic nb;

    always_comb begin
        nb = ~bit_b;
        // Majority of bit_a, inverted bit_b and the incoming carry.
        cout = (bit_a & nb) | (bit_a & cin) | (nb & cin);
    end

endmodule

// File: rtl/down_cell.sv
module down_cell
    import ripple_cmp_pkg::*;
(
    input  logic     bit_a,
    input  logic     bit_b,
    input  dn_link_t link_in,
    output dn_link_t link_out
);

    logic bits_match;
    logic local_win;

    always_comb begin
        bits_match     = ~(bit_a ^ bit_b);
        local_win      = bit_a & ~bit_b;
        link_out.ahead = link_in.ahead | (link_in.same & local_win);
        link_out.same  = link_in.same & bits_match;
    end

endmodule

// File: rtl/up_chain.sv
module up_chain #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] vec_a,
    input  logic [W-1:0] vec_b,
    output logic [W:0]   carries
);

    assign carries[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_up
        up_cell u_cell (
            .bit_a (vec_a[i]),
            .bit_b (vec_b[i]),
            .cin   (carries[i]),
            .cout  (carries[i+1])
        );
    end

endmodule

// File: rtl/down_chain.sv
module down_chain
    import ripple_cmp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] vec_a,
    input  logic [W-1:0] vec_b,
    output logic [W:0]   ahead_vec,
    output logic [W:0]   same_vec
);

    dn_link_t links [W+1];

    assign links[W] = DN_ENTRY;

    for (genvar i = W - 1; i >= 0; i--) begin : g_dn
        down_cell u_cell (
            .bit_a    (vec_a[i]),
            .bit_b    (vec_b[i]),
            .link_in  (links[i+1]),
            .link_out (links[i])
        );
    end

    for (genvar k = 0; k <= W; k++) begin : g_out
        assign ahead_vec[k] = links[k].ahead;
        assign same_vec[k]  = links[k].same;
    end

endmodule

// File: rtl/ripple_cmp_dual.sv
module ripple_cmp_dual
    import ripple_cmp_pkg::*;
#(
    parameter int unsigned W = CMP_WIDTH
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         gt_up,
    output logic         gt_down,
    output logic         agree,
    output logic         equal,
    output logic [W:0]   up_carry,
    output logic [W:0]   dn_g,
    output logic [W:0]   dn_e
);

    up_chain #(.W(W)) u_up (
        .vec_a   (op_a),
        .vec_b   (op_b),
        .carries (up_carry)
    );

    down_chain #(.W(W)) u_down (
        .vec_a     (op_a),
        .vec_b     (op_b),
        .ahead_vec (dn_g),
        .same_vec  (dn_e)
    );

    always_comb begin
        gt_up   = up_carry[W];
        gt_down = dn_g[0];
        agree   = ~(gt_up ^ gt_down);
        equal   = dn_e[0];
    end

endmodule

// File: rtl/ripple_cmp_dual_chk.sv
module ripple_cmp_dual_chk #(
    parameter int unsigned W = 8
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         gt_up,
    input logic         gt_down,
    input logic         agree,
    input logic         equal,
    input logic [W:0]   up_carry,
    input logic [W:0]   dn_g,
    input logic [W:0]   dn_e
);

    always_comb begin
        AST_UP_RESULT: assert (gt_up == (op_a > op_b));                // R1
        AST_DOWN_RESULT: assert (gt_down == (op_a > op_b));            // R3
        AST_CHAINS_AGREE: assert (agree && (gt_up == gt_down));        // R5
        AST_EQ_NOT_GT: assert (!(equal && (gt_up || gt_down)));        // R6
        AST_EQ_MATCH: assert (equal == (op_a == op_b));                // R6
        for (int i = 0; i < W; i++) begin
            if (op_a[i] != op_b[i]) begin
                AST_UP_CELL_DIFF: assert (up_carry[i+1] == op_a[i]);   // R2
            end else begin
                AST_UP_CELL_PASS: assert (up_carry[i+1] == up_carry[i]); // R2
            end
            AST_DN_G_STICKY: assert (!dn_g[i+1] || dn_g[i]);           // R4
            AST_DN_E_PREFIX: assert (!dn_e[i] || dn_e[i+1]);           // R4
        end
        for (int k = 0; k <= W; k++) begin
            AST_DN_EXCLUSIVE: assert (!(dn_g[k] && dn_e[k]));          // R4
        end
    end

endmodule

bind ripple_cmp_dual ripple_cmp_dual_chk #(.W(W)) u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .gt_up    (gt_up),
    .gt_down  (gt_down),
    .agree    (agree),
    .equal    (equal),
    .up_carry (up_carry),
    .dn_g     (dn_g),
    .dn_e     (dn_e)
);

// File: tb/ripple_cmp_dual_tb.sv
module ripple_cmp_dual_tb;

    localparam int unsigned W = 8;
    localparam int unsigned WATCHDOG_CYCLES = 150000;

    typedef struct {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         gt;
        logic         eq;
        logic [W:0]   carry;
        logic [W:0]   g;
        logic [W:0]   e;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic gt_up, gt_down, agree, equal;
    logic [W:0] up_carry, dn_g, dn_e;

    exp_item_t sb_q[$];
    int n_checks = 0;
    int n_fails  = 0;
    bit drive_done = 1'b0;
    bit timed_out  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ripple_cmp_dual #(.W(W)) u_dut (
        .op_a     (op_a),
        .op_b     (op_b),
        .gt_up    (gt_up),
        .gt_down  (gt_down),
        .agree    (agree),
        .equal    (equal),
        .up_carry (up_carry),
        .dn_g     (dn_g),
        .dn_e     (dn_e)
    );

    function automatic exp_item_t model(input logic [W-1:0] a, input logic [W-1:0] b);
        exp_item_t it;
        it.a  = a;
        it.b  = b;
        it.gt = (a > b);
        it.eq = (a == b);
        for (int i = 0; i <= W; i++) begin
            logic [W-1:0] mask;
            mask        = (i == 0) ? '0 : (W'((1 << i) - 1));
            it.carry[i] = ((a & mask) > (b & mask));
            it.g[i]     = ((a >> i) > (b >> i));
            it.e[i]     = ((a >> i) == (b >> i));
        end
        return it;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W:0] act, input logic [W:0] exp,
                         input exp_item_t it);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s a=%0d b=%0d actual=%b expected=%b",
                     tag, what, it.a, it.b, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        sb_q.push_back(model(a, b));
    endtask

    // Monitor: compares the settled outputs for the item driven at the last falling edge.
    initial begin
        forever begin
            @(posedge clk);
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                check("R1", "gt_up",    {{W{1'b0}}, gt_up},   {{W{1'b0}}, it.gt}, it);
                check("R2", "up_carry", up_carry,             it.carry,           it);
                check("R3", "gt_down",  {{W{1'b0}}, gt_down}, {{W{1'b0}}, it.gt}, it);
                check("R4", "dn_g",     dn_g,                 it.g,               it);
                check("R4", "dn_e",     dn_e,                 it.e,               it);
                check("R5", "agree",    {{W{1'b0}}, agree},   {{W{1'b0}}, 1'b1},  it);
                check("R6", "equal",    {{W{1'b0}}, equal},   {{W{1'b0}}, it.eq}, it);
            end
        end
    end

    // Driver: directed corner cases first, then every operand pair.
    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(8'd0,   8'd0);     // idle state after start: equal, not greater (R6)
        drive(8'd89,  8'd116);   // decided low in the upward chain (R1)
        drive(8'd89,  8'd3);     // decided at bit 6, early in the downward chain (R4)
        drive(8'd1,   8'd0);     // decided only at bit 0 (R2)
        drive(8'd89,  8'd84);    // decided at bit 3 (R3)
        drive(8'd255, 8'd255);   // all ones equal (R6)
        drive(8'd128, 8'd127);   // MSB decides against all lower bits (R2)
        drive(8'd127, 8'd128);   // MSB decides the other way (R4)
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                drive(W'(a), W'(b));   // full sweep (R1, R3, R5)
            end
        end
        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        drive_done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc;
        cyc = 0;
        while (!drive_done && cyc < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cyc++;
        end
        if (!drive_done) begin
            timed_out = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule